// File: doc/BRIEF.md
# Short Backward Branch Folder

This fetch-side unit watches the stream of decoded instructions for a taken PC-relative branch that jumps back by only a short distance. Such a branch closes a small loop. When the unit sees one, it remembers where the branch sits and where the loop starts. It seeds a small counter from the branch's own displacement field. The counter then steps once for every instruction that executes in sequence.

When the counter shows that the next instruction would be the loop branch again, the unit folds the branch away. It raises a one-cycle fold pulse together with the loop-start address, so fetch returns to the top of the loop without issuing the branch. Loops are recognised purely from ordinary branches, so no dedicated loop opcodes are needed.

Tracking ends in any of these cases:
- another transfer of control is taken;
- the tracked branch is seen falling through;
- the late outcome of a folded branch turns out to be not taken.

Top module: `sbb_folder`

## Requirements
- R1: After reset, and until a qualifying branch has been taken, `fold_o` is 0 and `fold_target_o` is 0.
- R2: A taken branch (`ins_is_br_i`=1, `ins_taken_i`=1) starts tracking only if its displacement, a signed count of instructions, lies in -1..-32. Any other displacement, such as -33, 0 or positive values, stops tracking and never leads to a fold.
- R3: The branch itself executes normally on its first pass. After a tracked branch with displacement d is taken, `fold_o` pulses high in the cycle after the |d|-th following sequential instruction is accepted.
- R4: While `fold_o` is 1, `fold_target_o` equals the branch PC plus the displacement times 4. PCs are byte addresses of 4-byte instructions. While `fold_o` is 0, `fold_target_o` is 0.
- R5: After a fold, the count restarts from the displacement, so every later iteration of |d| sequential instructions folds again.
- R6: An accepted jump (`ins_is_jmp_i`=1) or a taken ineligible branch clears tracking. A taken eligible branch at a different PC re-targets tracking to itself, which is how an inner loop takes over.
- R7: If the tracked branch PC is seen in the stream as not taken, tracking ends. Not-taken branches at other PCs count as ordinary sequential instructions.
- R8: A resolution report with `res_valid_i`=1 and `res_taken_i`=0 clears tracking, and takes priority over the instruction in the same cycle. A report with `res_taken_i`=1 has no effect.
- R9: Cycles with `ins_valid_i`=0 do not advance the count and never produce a fold in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | An instruction executes this cycle |
| ins_pc_i | input | PC_W | Byte address of that instruction |
| ins_is_br_i | input | 1 | Instruction is a PC-relative conditional branch |
| ins_is_jmp_i | input | 1 | Instruction is an unconditional jump or other transfer |
| ins_taken_i | input | 1 | Resolved outcome of the branch this cycle |
| ins_disp_i | input | DISP_W | Signed branch displacement in instructions |
| res_valid_i | input | 1 | Late outcome of the last folded branch is reported |
| res_taken_i | input | 1 | That outcome was taken |
| fold_o | output | 1 | One-cycle fold pulse: redirect fetch, skip the branch |
| fold_target_o | output | PC_W | Loop start address during a fold, else 0 |

## Verification
The bench builds the block with its default parameters: a 5-bit counter, a 12-bit displacement and 32-bit byte-addressed PCs. These values put both limits of the eligible window (-1 and -32) within reach. They also put the first value outside it (-33) and positive displacements within reach. Against a behavioural model that tracks the loop position as an integer, the bench drives single loops of both boundary sizes and bubbles inside loop bodies. It also drives a nested inner loop that takes over from the outer one, jumps and fall-throughs, and resolution reports of both outcomes.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Per-cycle action on the loop tracker
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_CLEAR = 2'd1,
    EV_LOAD  = 2'd2,
    EV_STEP  = 2'd3
  } ev_e;
endpackage

// File: rtl/sbf_detect.sv
module sbf_detect #(
  parameter int PC_W    = 32,
  parameter int DISP_W  = 12,
  parameter int CNT_W   = 5,
  parameter int ISZ_LG2 = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              eligible_o,
  output logic [PC_W-1:0]   target_o
);
  localparam int HI_W = DISP_W - CNT_W;
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  // -1..-(2**CNT_W): every bit above the counter field is one
  assign eligible_o = &disp_i[DISP_W-1 -: HI_W];
  assign disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  generate
    if (ISZ_LG2 == 0) begin : g_word
      assign target_o = pc_i + disp_ext;
    end else begin : g_byte
      assign target_o = pc_i + {disp_ext[PC_W-1-ISZ_LG2:0], {ISZ_LG2{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/sbf_classify.sv
module sbf_classify
  import sbf_pkg::*;
(
  input  logic valid_i,
  input  logic is_br_i,
  input  logic is_jmp_i,
  input  logic taken_i,
  input  logic res_valid_i,
  input  logic res_taken_i,
  input  logic tracking_i,
  input  logic pc_match_i,
  input  logic eligible_i,
  output ev_e  ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (res_valid_i && !res_taken_i) begin
      ev_o = EV_CLEAR;
    end else if (valid_i) begin
      if (is_br_i && taken_i && eligible_i)      ev_o = EV_LOAD;
      else if (is_jmp_i || (is_br_i && taken_i)) ev_o = EV_CLEAR;
      else if (is_br_i && tracking_i && pc_match_i) ev_o = EV_CLEAR;
      else if (tracking_i)                       ev_o = EV_STEP;
    end
  end
endmodule

// File: rtl/sbf_loop_ctr.sv
module sbf_loop_ctr
  import sbf_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ev_e              ev_i,
  input  logic [CNT_W-1:0] seed_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, seed_q;

  // all ones = last body instruction before the branch
  assign wrap_o = (ev_i == EV_STEP) && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seed_q <= '0;
    end else begin
      unique case (ev_i)
        EV_LOAD: begin
          cnt_q  <= seed_i;
          seed_q <= seed_i;
        end
        EV_CLEAR: cnt_q <= '0;
        EV_STEP:  cnt_q <= wrap_o ? seed_q : cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sbb_folder.sv
module sbb_folder
  import sbf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DISP_W  = 12,
  parameter int CNT_W   = 5,
  parameter int ISZ_LG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [PC_W-1:0]   ins_pc_i,
  input  logic              ins_is_br_i,
  input  logic              ins_is_jmp_i,
  input  logic              ins_taken_i,
  input  logic [DISP_W-1:0] ins_disp_i,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  output logic              fold_o,
  output logic [PC_W-1:0]   fold_target_o
);
  logic            eligible, wrap, pc_match;
  logic [PC_W-1:0] target;
  ev_e             ev;

  logic            tracking_q, fold_q;
  logic [PC_W-1:0] br_pc_q, tgt_q;

  sbf_detect #(
    .PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W), .ISZ_LG2(ISZ_LG2)
  ) u_detect (
    .pc_i      (ins_pc_i),
    .disp_i    (ins_disp_i),
    .eligible_o(eligible),
    .target_o  (target)
  );

  assign pc_match = (br_pc_q == ins_pc_i);

  sbf_classify u_classify (
    .valid_i    (ins_valid_i),
    .is_br_i    (ins_is_br_i),
    .is_jmp_i   (ins_is_jmp_i),
    .taken_i    (ins_taken_i),
    .res_valid_i(res_valid_i),
    .res_taken_i(res_taken_i),
    .tracking_i (tracking_q),
    .pc_match_i (pc_match),
    .eligible_i (eligible),
    .ev_o       (ev)
  );

  sbf_loop_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .seed_i(ins_disp_i[CNT_W-1:0]),
    .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tracking_q <= 1'b0;
      br_pc_q    <= '0;
      tgt_q      <= '0;
      fold_q     <= 1'b0;
    end else begin
      fold_q <= wrap;
      if (ev == EV_LOAD) begin
        tracking_q <= 1'b1;
        br_pc_q    <= ins_pc_i;
        tgt_q      <= target;
      end else if (ev == EV_CLEAR) begin
        tracking_q <= 1'b0;
      end
    end
  end

  assign fold_o        = fold_q;
  assign fold_target_o = fold_q ? tgt_q : '0;
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ins_valid_i,
  input logic              ins_is_br_i,
  input logic              ins_is_jmp_i,
  input logic              ins_taken_i,
  input logic [DISP_W-1:0] ins_disp_i,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic              fold_o,
  input logic [PC_W-1:0]   fold_target_o
);
  assert_no_fold_nonneg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_is_br_i && ins_taken_i && !ins_disp_i[DISP_W-1]) |=> !fold_o);

  assert_target_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fold_o |-> (fold_target_o == '0));

  assert_jump_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_is_jmp_i && !ins_is_br_i) |=> !fold_o);

  assert_res_not_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_taken_i) |=> !fold_o);

  assert_bubble_no_fold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_i |=> !fold_o);
endmodule

bind sbb_folder sbf_checker #(.PC_W(PC_W), .DISP_W(DISP_W)) u_sbf_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ins_valid_i  (ins_valid_i),
  .ins_is_br_i  (ins_is_br_i),
  .ins_is_jmp_i (ins_is_jmp_i),
  .ins_taken_i  (ins_taken_i),
  .ins_disp_i   (ins_disp_i),
  .res_valid_i  (res_valid_i),
  .res_taken_i  (res_taken_i),
  .fold_o       (fold_o),
  .fold_target_o(fold_target_o)
);

// File: tb/sim_sbb_folder.sv
module sim_sbb_folder;
  localparam int PC_W = 32;
  localparam int DISP_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid_i = 0, ins_is_br_i = 0, ins_is_jmp_i = 0, ins_taken_i = 0;
  logic [PC_W-1:0] ins_pc_i = '0;
  logic [DISP_W-1:0] ins_disp_i = '0;
  logic res_valid_i = 0, res_taken_i = 0;
  logic fold_o;
  logic [PC_W-1:0] fold_target_o;

  always #4 clk = ~clk;  // 125 MHz

  sbb_folder u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid_i), .ins_pc_i(ins_pc_i),
    .ins_is_br_i(ins_is_br_i), .ins_is_jmp_i(ins_is_jmp_i),
    .ins_taken_i(ins_taken_i), .ins_disp_i(ins_disp_i),
    .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .fold_o(fold_o), .fold_target_o(fold_target_o)
  );

  int checks = 0, errors = 0, cycles = 0, folds_seen = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit trk = 0, exp_fold = 0;
  int bpc = 0, bd = 0, pos = 0;
  logic [PC_W-1:0] exp_tgt = '0;

  task automatic check(input string req, input bit act_f, input bit exp_f,
                       input logic [PC_W-1:0] act_t, input logic [PC_W-1:0] exp_t);
    checks++;
    if (act_f !== exp_f || act_t !== exp_t) begin
      errors++;
      $display("FAIL %s fold=%0d target=%h expected fold=%0d target=%h",
               req, act_f, act_t, exp_f, exp_t);
    end
  endtask

  task automatic model_update();
    int d;
    d = $signed(ins_disp_i);
    exp_fold = 0;
    if (res_valid_i && !res_taken_i) trk = 0;
    else if (ins_valid_i) begin
      if (ins_is_jmp_i || (ins_is_br_i && ins_taken_i)) begin
        if (ins_is_br_i && ins_taken_i && d <= -1 && d >= -32) begin
          trk = 1; bpc = int'(ins_pc_i); bd = d; pos = d;
        end else trk = 0;
      end else if (ins_is_br_i && trk && int'(ins_pc_i) == bpc) trk = 0;
      else if (trk) begin
        pos++;
        if (pos == 0) begin
          exp_fold = 1; pos = bd;
        end
      end
    end
    exp_tgt = exp_fold ? PC_W'(bpc + bd * 4) : '0;
  endtask

  task automatic cyc(input bit v, input int idx, input bit br, input bit jmp,
                     input int d, input bit tk, input bit rv, input bit rt);
    ins_valid_i = v; ins_pc_i = PC_W'(idx * 4); ins_is_br_i = br;
    ins_is_jmp_i = jmp; ins_taken_i = tk; ins_disp_i = DISP_W'(d);
    res_valid_i = rv; res_taken_i = rt;
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (fold_o) folds_seen++;
    check(cur_req, fold_o, exp_fold, fold_target_o, exp_tgt);
  endtask

  task automatic seq(input int idx);
    cyc(1, idx, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic body(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) seq(i);
  endtask

  task automatic br(input int idx, input int d, input bit tk);
    cyc(1, idx, 1, 0, d, tk, 0, 0);
  endtask

  task automatic count_check(input string req, input int exp_n);
    checks++;
    if (folds_seen != exp_n) begin
      errors++;
      $display("FAIL %s fold count=%0d expected=%0d", req, folds_seen, exp_n);
    end
    folds_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", fold_o, 1'b0, fold_target_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: plain code without taken branches never folds
    cur_req = "R1";
    body(0, 40);
    count_check("R1", 0);

    // R2: ineligible displacements -33 and +5
    cur_req = "R2";
    br(100, -33, 1); body(67, 99); body(67, 99);
    br(120, 5, 1); body(125, 160);
    br(200, 0, 1); body(200, 210);
    count_check("R2", 0);

    // R3/R5: loop of 4, several iterations
    cur_req = "R3";
    body(300, 303); br(304, -4, 1);
    for (int k = 0; k < 5; k++) body(300, 303);
    count_check("R5", 5);
    // R8: taken report has no effect, not-taken report clears
    cur_req = "R8";
    cyc(1, 300, 0, 0, 0, 0, 1, 1); body(301, 303);
    count_check("R8", 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0); body(305, 330);
    count_check("R8", 0);

    // R2/R3 boundaries: -1 and -32
    cur_req = "R2";
    seq(400); br(401, -1, 1);
    for (int k = 0; k < 4; k++) seq(400);
    count_check("R3", 4);
    br(401, -1, 0);
    cur_req = "R7";
    body(402, 420);
    count_check("R7", 0);
    cur_req = "R2";
    body(500, 531); br(532, -32, 1);
    for (int k = 0; k < 3; k++) body(500, 531);
    count_check("R3", 3);

    // R9: bubbles inside the loop body
    cur_req = "R9";
    br(610, -6, 1);
    for (int k = 0; k < 3; k++)
      for (int i = 604; i <= 609; i++) begin
        seq(i);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
      end
    count_check("R9", 3);

    // R6: jump inside a tracked loop clears
    cur_req = "R6";
    br(710, -5, 1); body(705, 707);
    cyc(1, 708, 0, 1, 0, 1, 0, 0);
    body(900, 930);
    count_check("R6", 0);

    // R6: nested loops; inner takes over, outer reacquired
    cur_req = "R6";
    body(1000, 1005); br(1006, -3, 1);
    for (int k = 0; k < 3; k++) body(1003, 1005);
    cyc(1, 1003, 0, 0, 0, 0, 1, 0);        // inner exits (report not taken)
    body(1004, 1005); br(1006, -3, 0);
    body(1007, 1009); br(1010, -10, 1);   // outer loop branch
    body(1000, 1005); br(1006, -3, 1);    // inner reacquired
    body(1003, 1005);
    count_check("R6", 4);

    // R7: a non-tracked not-taken branch counts as a body instruction
    cur_req = "R7";
    br(1106, -6, 1);
    for (int k = 0; k < 2; k++) begin
      body(1100, 1102); br(1103, 20, 0); body(1104, 1105);
    end
    count_check("R7", 2);

    // R4: target check with a large PC
    cur_req = "R4";
    br(40000, -7, 1); body(39993, 39999);
    count_check("R4", 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule